// File: doc/BRIEF.md
# Channel Interleave Address Hasher

This block takes a physical byte address and returns the memory channel that owns it, the global sub-partition that serves it, and the address bits that remain above the channel and sub-partition fields. It sits in a request pipeline between a requester and a set of memory channels. Each request passes through one register stage with a valid/ready handshake.

Three mapping modes are chosen per request. Linear mode takes the channel and sub-partition fields straight from the address. XOR mode folds the low bits of the remaining high address bits into the channel field. Polynomial mode spreads power-of-two strides across channels by XOR-reducing selected high address bits into each channel bit, using fixed tap sets that come from residues of an irreducible polynomial over GF(2). In two-sub-partition configurations the sub-partition bit is hashed as well. The channel count, the sub-partitions per channel and the field base position are elaboration parameters. Polynomial mode has tap sets for only three shapes, and any other shape raises an error flag.

Top module: `chan_hash_map`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `out_valid` is 0 and `in_ready` is 1.
- R2: With `in_mode` = 0 (linear), the sub-partition bits are `addr[BASE +: SW]` and the channel is `addr[BASE+SW +: CW]`. Here BASE is `CH_BASE`, CW = log2(NUM_CH) and SW = log2(SUB_PER_CH).
- R3: `out_high` equals the input address shifted right by BASE+CW+SW, zero-filled, in every mode. Call it `h`.
- R4: With `in_mode` = 1 (XOR), the channel is the linear channel XOR `h[CW-1:0]`, and the sub-partition bits are the linear ones.
- R5: With `in_mode` = 2 and 32 channels × 1 sub-partition, channel bit k is the parity of `h` over a tap set, XOR linear channel bit k. The tap sets are: bit0 {0,3,5,6,9,10,11,12,13}, bit1 {1,4,6,7,10,11,12,13,14}, bit2 {0,2,3,6,7,8,9,10,14}, bit3 {1,3,4,7,8,9,10,11}, bit4 {2,4,5,8,9,10,11,12}.
- R6: With `in_mode` = 2 and 16 channels × 2 sub-partitions, channel bits 0..3 use the R5 tap sets for bits 0..3. The sub-partition bit is the parity of `h` over {2,4,5,8,9,10,11,12}, XOR the linear sub-partition bit.
- R7: With `in_mode` = 2 and 32 channels × 2 sub-partitions, the tap sets are: bit0 {0,5,6,10,12,15,16,17,18}, bit1 {0,1,5,7,10,11,12,13,15}, bit2 {1,2,6,8,11,12,13,14,16}, bit3 {2,3,7,9,12,13,14,15,17}, bit4 {3,4,8,10,13,14,15,16,18}. The sub-partition bit uses {4,5,9,11,14,15,16,17}, XOR the linear sub-partition bit.
- R8: `out_gid` = channel × SUB_PER_CH + sub-partition bits. It is always below NUM_CH × SUB_PER_CH.
- R9: `out_err` is 1 when `in_mode` = 3, or when `in_mode` = 2 on a shape not listed in R5–R7. Such a request is then mapped as in linear mode. In modes 0 and 1 `out_err` is 0.
- R10: A request accepted at a clock edge (`in_valid` and `in_ready` both high) appears on the outputs with `out_valid` high right after that edge. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. `out_valid` drops after an edge with `out_ready` high and no new request.
- R11: While `out_valid` is high and `out_ready` is low, all outputs hold their values and no new request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Stage can take a request this cycle |
| in_addr | input | ADDR_W | Physical byte address |
| in_mode | input | 2 | 0 linear, 1 XOR, 2 polynomial, 3 reserved |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_chan | output | log2(NUM_CH) | Channel index |
| out_gid | output | log2(NUM_CH×SUB_PER_CH) | Global sub-partition index |
| out_high | output | ADDR_W | Address bits above the channel field |
| out_err | output | 1 | Mode not usable for this configuration |

## Verification
A wrong tap in a hash equation appears as a flipped channel or sub-partition bit on the first accepted request that has that high-address bit set. It shows one edge after acceptance. The bench therefore walks single-bit and small-multiple strides across every high bit in every mode, on four configurations at once. A corrupted holding register appears as changing outputs during a stall, or as a dropped or duplicated `out_valid`. The bench watches for this across a stall several cycles long.

// File: rtl/chm_pkg.sv
// Shared types and hash equations for the channel interleave hasher.
// Assumes the hash operand is the zero-filled high address bits, HASH_W wide.
package chm_pkg;

    typedef enum logic [1:0] {
        MAP_LINEAR = 2'd0,
        MAP_XOR    = 2'd1,
        MAP_POLY   = 2'd2,
        MAP_RSVD   = 2'd3
    } map_mode_e;

    localparam int HASH_W = 19;

    // Channel bits for the narrow polynomial (32x1 uses all five, 16x2 the low four).
    function automatic logic [4:0] poly_chan_lo(input logic [HASH_W-1:0] a, input logic [4:0] c);
        logic [4:0] r;
        r[0] = c[0] ^ a[0] ^ a[3] ^ a[5] ^ a[6] ^ a[9] ^ a[10] ^ a[11] ^ a[12] ^ a[13];
        r[1] = c[1] ^ a[1] ^ a[4] ^ a[6] ^ a[7] ^ a[10] ^ a[11] ^ a[12] ^ a[13] ^ a[14];
        r[2] = c[2] ^ a[0] ^ a[2] ^ a[3] ^ a[6] ^ a[7] ^ a[8] ^ a[9] ^ a[10] ^ a[14];
        r[3] = c[3] ^ a[1] ^ a[3] ^ a[4] ^ a[7] ^ a[8] ^ a[9] ^ a[10] ^ a[11];
        r[4] = c[4] ^ a[2] ^ a[4] ^ a[5] ^ a[8] ^ a[9] ^ a[10] ^ a[11] ^ a[12];
        return r;
    endfunction

    // Sub-partition bit for the 16x2 shape.
    function automatic logic poly_sub_lo(input logic [HASH_W-1:0] a, input logic b);
        return b ^ a[2] ^ a[4] ^ a[5] ^ a[8] ^ a[9] ^ a[10] ^ a[11] ^ a[12];
    endfunction

    // Channel bits for the wide polynomial used by the 32x2 shape.
    function automatic logic [4:0] poly_chan_hi(input logic [HASH_W-1:0] a, input logic [4:0] c);
        logic [4:0] r;
        r[0] = c[0] ^ a[0] ^ a[5] ^ a[6] ^ a[10] ^ a[12] ^ a[15] ^ a[16] ^ a[17] ^ a[18];
        r[1] = c[1] ^ a[0] ^ a[1] ^ a[5] ^ a[7] ^ a[10] ^ a[11] ^ a[12] ^ a[13] ^ a[15];
        r[2] = c[2] ^ a[1] ^ a[2] ^ a[6] ^ a[8] ^ a[11] ^ a[12] ^ a[13] ^ a[14] ^ a[16];
        r[3] = c[3] ^ a[2] ^ a[3] ^ a[7] ^ a[9] ^ a[12] ^ a[13] ^ a[14] ^ a[15] ^ a[17];
        r[4] = c[4] ^ a[3] ^ a[4] ^ a[8] ^ a[10] ^ a[13] ^ a[14] ^ a[15] ^ a[16] ^ a[18];
        return r;
    endfunction

    // Sub-partition bit for the 32x2 shape.
    function automatic logic poly_sub_hi(input logic [HASH_W-1:0] a, input logic b);
        return b ^ a[4] ^ a[5] ^ a[9] ^ a[11] ^ a[14] ^ a[15] ^ a[16] ^ a[17];
    endfunction

endpackage

// File: rtl/chm_field_split.sv
// Splits an address into the linear sub-partition field, the linear channel
// field above it, and the zero-filled high bits above both.
// Assumes CH_BASE >= 1 and CH_BASE + CH_W + SUB_W < ADDR_W.
module chm_field_split #(
    parameter int ADDR_W  = 40,
    parameter int CH_BASE = 8,
    parameter int CH_W    = 5,
    parameter int SUB_W   = 1,
    parameter int SUBX    = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   lin_chan,
    output logic [SUBX-1:0]   lin_sub,
    output logic [ADDR_W-1:0] high
);
    localparam int SHIFT = CH_BASE + CH_W + SUB_W;

    // Byte offset bits below the channel field do not take part in the mapping.
    logic unused_low;
    assign unused_low = ^addr[CH_BASE-1:0];

    // Channel field sits directly above the sub-partition field.
    assign lin_chan = addr[CH_BASE+SUB_W +: CH_W];
    assign high     = addr >> SHIFT;

    // The sub-partition field exists only when there is more than one sub-partition.
    generate
        if (SUB_W > 0) begin : g_sub
            assign lin_sub = addr[CH_BASE +: SUB_W];
        end else begin : g_nosub
            assign lin_sub = '0;
        end
    endgenerate
endmodule

// File: rtl/chm_chan_hash.sv
// Picks the channel and sub-partition bits for the selected mode. The
// polynomial variant is chosen at elaboration from the channel/sub-partition
// shape; shapes without tap sets flag an error and fall back to linear.
module chm_chan_hash
    import chm_pkg::*;
#(
    parameter int NUM_CH     = 32,
    parameter int SUB_PER_CH = 2,
    parameter int CH_W       = 5,
    parameter int SUBX       = 1
) (
    input  map_mode_e         mode,
    input  logic [CH_W-1:0]   lin_chan,
    input  logic [SUBX-1:0]   lin_sub,
    input  logic [HASH_W-1:0] a,
    output logic [CH_W-1:0]   chan,
    output logic [SUBX-1:0]   sub,
    output logic              err
);
    localparam bit SHAPE_32_1 = (NUM_CH == 32) && (SUB_PER_CH == 1);
    localparam bit SHAPE_16_2 = (NUM_CH == 16) && (SUB_PER_CH == 2);
    localparam bit SHAPE_32_2 = (NUM_CH == 32) && (SUB_PER_CH == 2);

    logic [CH_W-1:0] poly_chan;
    logic [SUBX-1:0] poly_sub;
    logic            poly_ok;
    logic [4:0]      poly_tmp;

    // Select the tap-set family that matches the configured shape.
    generate
        if (SHAPE_32_1) begin : g_p32x1
            assign poly_tmp  = poly_chan_lo(a, 5'(lin_chan));
            assign poly_chan = poly_tmp[CH_W-1:0];
            assign poly_sub  = lin_sub;
            assign poly_ok   = 1'b1;
        end else if (SHAPE_16_2) begin : g_p16x2
            assign poly_tmp  = poly_chan_lo(a, 5'(lin_chan));
            assign poly_chan = poly_tmp[CH_W-1:0];
            assign poly_sub  = SUBX'(poly_sub_lo(a, lin_sub[0]));
            assign poly_ok   = 1'b1;
        end else if (SHAPE_32_2) begin : g_p32x2
            assign poly_tmp  = poly_chan_hi(a, 5'(lin_chan));
            assign poly_chan = poly_tmp[CH_W-1:0];
            assign poly_sub  = SUBX'(poly_sub_hi(a, lin_sub[0]));
            assign poly_ok   = 1'b1;
        end else begin : g_pnone
            assign poly_tmp  = '0;
            assign poly_chan = lin_chan;
            assign poly_sub  = lin_sub;
            assign poly_ok   = 1'b0;
        end
    endgenerate

    // Mode multiplexer; illegal selections map linearly and raise err.
    always_comb begin
        chan = lin_chan;
        sub  = lin_sub;
        err  = 1'b0;
        unique case (mode)
            MAP_LINEAR: ;
            MAP_XOR:    chan = lin_chan ^ a[CH_W-1:0];
            MAP_POLY: begin
                chan = poly_chan;
                sub  = poly_sub;
                err  = !poly_ok;
            end
            default:    err = 1'b1;
        endcase
    end
endmodule

// File: rtl/chm_out_stage.sv
// One register stage with valid/ready flow control. A result is held while
// the consumer stalls; ready to the producer passes through combinationally.
module chm_out_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    // Stage is free when empty or when its content leaves this cycle.
    assign in_ready = !out_valid || out_ready;

    // Valid flag follows the producer whenever the stage is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    // Capture payload only on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (in_valid && in_ready) begin
            out_data <= in_data;
        end
    end

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10
    accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R10
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && out_ready) |=> !out_valid);
endmodule

// File: rtl/chan_hash_map.sv
// Top of the channel interleave hasher: splits the address, hashes the
// channel/sub-partition bits per mode and registers the result.
// Assumes NUM_CH and SUB_PER_CH are powers of two, NUM_CH >= 2, and
// ADDR_W >= HASH_W so the hash operand is fully available.
module chan_hash_map
    import chm_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int CH_BASE    = 8,
    parameter int NUM_CH     = 32,
    parameter int SUB_PER_CH = 2,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int SUB_W     = $clog2(SUB_PER_CH),
    localparam int GID_W     = CH_W + SUB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CH_W-1:0]   out_chan,
    output logic [GID_W-1:0]  out_gid,
    output logic [ADDR_W-1:0] out_high,
    output logic              out_err
);
    localparam int SUBX = (SUB_W > 0) ? SUB_W : 1;
    localparam int DW   = 1 + ADDR_W + GID_W + CH_W;

    logic [CH_W-1:0]   lin_chan, h_chan;
    logic [SUBX-1:0]   lin_sub, h_sub;
    logic [ADDR_W-1:0] high;
    logic [GID_W-1:0]  gid;
    logic              h_err;
    logic [DW-1:0]     stage_out;

    chm_field_split #(
        .ADDR_W(ADDR_W), .CH_BASE(CH_BASE), .CH_W(CH_W), .SUB_W(SUB_W), .SUBX(SUBX)
    ) u_split (
        .addr(in_addr), .lin_chan(lin_chan), .lin_sub(lin_sub), .high(high)
    );

    chm_chan_hash #(
        .NUM_CH(NUM_CH), .SUB_PER_CH(SUB_PER_CH), .CH_W(CH_W), .SUBX(SUBX)
    ) u_hash (
        .mode(map_mode_e'(in_mode)), .lin_chan(lin_chan), .lin_sub(lin_sub),
        .a(high[HASH_W-1:0]), .chan(h_chan), .sub(h_sub), .err(h_err)
    );

    // Global id = channel * sub-partitions + local sub-partition.
    generate
        if (SUB_W > 0) begin : g_gid
            assign gid = {h_chan, h_sub[SUB_W-1:0]};
        end else begin : g_gid1
            logic unused_sub;
            assign unused_sub = ^h_sub;
            assign gid = h_chan;
        end
    endgenerate

    chm_out_stage #(.DW(DW)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_data({h_err, high, gid, h_chan}),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(stage_out)
    );

    assign {out_err, out_high, out_gid, out_chan} = stage_out;

    // R2
    linear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mode == 2'd0)
        |=> (out_chan == $past(in_addr[CH_BASE+SUB_W +: CH_W])));

    // R9
    xor_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mode == 2'd1) |=> !out_err);
endmodule

// File: tb/chan_hash_map_test.sv
`timescale 1ns/1ps
module chan_hash_map_test;
    localparam logic [18:0] TAP_A [0:4] = '{19'h03E69, 19'h07CD2, 19'h047CD, 19'h00F9A, 19'h01F34};
    localparam logic [18:0] TAP_B [0:5] = '{19'h79461, 19'h0BCA3, 19'h17946, 19'h2F28C, 19'h5E518, 19'h3CA30};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [39:0] in_addr = '0;
    logic [1:0]  in_mode = 2'd0;
    logic        out_ready = 1'b1;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    logic r0, r1, r2, r3, v0, v1, v2, v3, e0, e1, e2, e3;
    logic [4:0] c0; logic [5:0] g0; logic [39:0] h0;
    logic [3:0] c1; logic [4:0] g1; logic [39:0] h1;
    logic [4:0] c2; logic [4:0] g2; logic [39:0] h2;
    logic [2:0] c3; logic [2:0] g3; logic [39:0] h3;

    always #10 clk = ~clk;

    chan_hash_map #(.ADDR_W(40), .CH_BASE(8), .NUM_CH(32), .SUB_PER_CH(2)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(r0), .in_addr(in_addr),
        .in_mode(in_mode), .out_valid(v0), .out_ready(out_ready), .out_chan(c0),
        .out_gid(g0), .out_high(h0), .out_err(e0));
    chan_hash_map #(.ADDR_W(40), .CH_BASE(8), .NUM_CH(16), .SUB_PER_CH(2)) u16 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(r1), .in_addr(in_addr),
        .in_mode(in_mode), .out_valid(v1), .out_ready(out_ready), .out_chan(c1),
        .out_gid(g1), .out_high(h1), .out_err(e1));
    chan_hash_map #(.ADDR_W(40), .CH_BASE(8), .NUM_CH(32), .SUB_PER_CH(1)) u32s (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(r2), .in_addr(in_addr),
        .in_mode(in_mode), .out_valid(v2), .out_ready(out_ready), .out_chan(c2),
        .out_gid(g2), .out_high(h2), .out_err(e2));
    chan_hash_map #(.ADDR_W(40), .CH_BASE(8), .NUM_CH(8), .SUB_PER_CH(1)) u8 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(r3), .in_addr(in_addr),
        .in_mode(in_mode), .out_valid(v3), .out_ready(out_ready), .out_chan(c3),
        .out_gid(g3), .out_high(h3), .out_err(e3));

    task automatic chk(string tag, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Reference mapping computed from the requirement text.
    task automatic model(input int nch, input int nsub, input logic [39:0] addr, input int mode,
                         output int chan, output int gid, output logic [39:0] high, output bit err);
        int chw, sw, lc, ls, sub;
        logic [39:0] t;
        logic [18:0] a;
        chw = $clog2(nch);
        sw  = $clog2(nsub);
        high = addr >> (8 + chw + sw);
        a = high[18:0];
        t = addr >> (8 + sw);
        lc = int'(t[7:0]) & (nch - 1);
        ls = int'(addr[15:8]) & (nsub - 1);
        chan = lc; sub = ls; err = 1'b0;
        if (mode == 1) begin
            chan = lc ^ (int'(high[7:0]) & (nch - 1));
        end else if (mode == 2) begin
            if (nch == 32 && nsub == 1) begin
                chan = 0;
                for (int k = 0; k < 5; k++) chan |= ((int'(^(a & TAP_A[k]))) ^ ((lc >> k) & 1)) << k;
            end else if (nch == 16 && nsub == 2) begin
                chan = 0;
                for (int k = 0; k < 4; k++) chan |= ((int'(^(a & TAP_A[k]))) ^ ((lc >> k) & 1)) << k;
                sub = int'(^(a & TAP_A[4])) ^ (ls & 1);
            end else if (nch == 32 && nsub == 2) begin
                chan = 0;
                for (int k = 0; k < 5; k++) chan |= ((int'(^(a & TAP_B[k]))) ^ ((lc >> k) & 1)) << k;
                sub = int'(^(a & TAP_B[5])) ^ (ls & 1);
            end else begin
                err = 1'b1;
            end
        end else if (mode == 3) begin
            err = 1'b1;
        end
        gid = chan * nsub + sub;
    endtask

    task automatic verify(int nch, int nsub, string ptag, logic [39:0] addr, int mode,
                          int gc, int gg, logic [39:0] gh, logic ge, logic gv);
        int ec, eg; logic [39:0] eh; bit ee; string mtag;
        model(nch, nsub, addr, mode, ec, eg, eh, ee);
        mtag = (mode == 0) ? "R2 chan" : (mode == 1) ? "R4 chan" : (mode == 2) ? ptag : "R9 chan";
        chk("R10 valid", longint'(gv), 1);
        chk(mtag, gc, ec);
        chk("R8 gid", gg, eg);
        chk("R3 high", gh, eh);
        chk("R9 err", longint'(ge), longint'(ee));
    endtask

    task automatic verify_all(logic [39:0] addr, int mode);
        verify(32, 2, "R7 chan", addr, mode, int'(c0), int'(g0), h0, e0, v0);
        verify(16, 2, "R6 chan", addr, mode, int'(c1), int'(g1), h1, e1, v1);
        verify(32, 1, "R5 chan", addr, mode, int'(c2), int'(g2), h2, e2, v2);
        verify(8, 1, "R9 chan fallback", addr, mode, int'(c3), int'(g3), h3, e3, v3);
    endtask

    // Drive one request at a falling edge; results are sampled one falling edge later.
    task automatic apply(logic [39:0] addr, int mode);
        in_addr = addr; in_mode = 2'(mode); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        verify_all(addr, mode);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [39:0] sa, sb;
        int ec, eg; logic [39:0] eh; bit ee;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid", longint'(v0), 0);
        chk("R1 in_ready", longint'(r0), 1);

        // Power-of-two strides and small multiples over all modes and four shapes.
        for (int m = 0; m < 4; m++)
            for (int k = 7; k <= 30; k++)
                for (int i = 0; i < 32; i++)
                    apply(40'(i) << k, m);
        // Scattered addresses.
        for (int m = 0; m < 4; m++)
            for (int n = 0; n < 300; n++)
                apply(40'({$urandom, $urandom}), m);

        // R10: idle edge with consumer ready drops valid.
        @(negedge clk);
        chk("R10 idle drop", longint'(v0), 0);

        // R11: stall holds the result and blocks a second request.
        sa = 40'h12_3456_7800;
        sb = 40'h0F_EDCB_A900;
        out_ready = 1'b0;
        apply(sa, 2);
        in_addr = sb; in_mode = 2'd2; in_valid = 1'b1;
        #1;
        chk("R10 in_ready low on stall", longint'(r0), 0);
        model(32, 2, sa, 2, ec, eg, eh, ee);
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            chk("R11 hold valid", longint'(v0), 1);
            chk("R11 hold chan", int'(c0), ec);
            chk("R11 hold gid", int'(g0), eg);
            chk("R11 hold high", h0, eh);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        model(32, 2, sb, 2, ec, eg, eh, ee);
        chk("R10 release valid", longint'(v0), 1);
        chk("R10 release chan", int'(c0), ec);
        chk("R10 release gid", int'(g0), eg);
        @(negedge clk);
        chk("R10 drained", longint'(v0), 0);

        // R1: reset mid-stream clears the stage.
        in_valid = 1'b1; in_addr = sa;
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk("R1 reset valid", longint'(v0), 0);
        chk("R1 reset ready", longint'(r0), 1);
        finish_run();
    end
endmodule